// File: doc/BRIEF.md
# Cascadable Counter-Shift Register Slice

This block is a small register slice, four bits wide by default, that works as either a wrap-around up/down counter or a bidirectional shift register. A 3-bit mode input picks one operation for each rising clock edge: parallel load, count up, count down, shift toward the most significant bit, shift toward the least significant bit, invert, synchronous clear, or hold. An active-high master reset clears the register at once, without waiting for a clock edge.

Identical slices chain directly without glue logic. The active-low terminal-count output of one slice drives the chain-enable input of the next slice up. In counting modes this gives a wider synchronous counter. In the shift-up mode the same wire carries the top bit of the lower slice into the bottom bit of the upper slice. The chain-enable input also serves as the serial input for shift-up, and the top bit of the preset data serves as the serial input for shift-down.

Top module: `cnt_shift_slice`

## Requirements
- R1: While `mreset` is 1, `q` is all zeros at once, without waiting for a clock edge. Reset overrides every other input, including a clock edge that arrives during reset.
- R2: Mode 3'b000 (load) copies `pre_d` into `q` on the clock edge.
- R3: Mode 3'b001 (count up) with both enables low makes `q` the old value plus one, modulo 2^WIDTH. All ones wraps to zero.
- R4: Mode 3'b010 (count down) with both enables low makes `q` the old value minus one, modulo 2^WIDTH. Zero wraps to all ones.
- R5: The enables are active low. In modes 001 and 010, if `adv_en_n` or `chain_en_n` is 1, `q` keeps its value.
- R6: `tc_n` is 0 only in these cases: mode 001 with `q` all ones and `chain_en_n` 0, or mode 010 with `q` zero and `chain_en_n` 0. In modes 000, 101, 110 and 111, `tc_n` is 1.
- R7: Mode 3'b011 (shift up) moves each bit one place toward the MSB and drops the old MSB. The value of `chain_en_n` enters at bit 0. The shift takes place whatever the level of `adv_en_n`.
- R8: Mode 3'b100 (shift down) moves each bit one place toward bit 0 and drops the old bit 0. `pre_d[WIDTH-1]` enters at the MSB, and the other bits of `pre_d` are ignored. The shift takes place whatever the level of `adv_en_n`.
- R9: In modes 011 and 100, `tc_n` equals `q[WIDTH-1]`.
- R10: Mode 3'b101 inverts every bit of `q` on the clock edge.
- R11: Mode 3'b110 clears `q` to zero on the clock edge.
- R12: Mode 3'b111 keeps `q` unchanged, whatever `pre_d` and the enables do.
- R13: Two slices count 0 to 255 and wrap to 0 in mode 001. For this, the upper slice's `chain_en_n` is wired to the lower slice's `tc_n`, the lower slice's `chain_en_n` is tied low, and `adv_en_n` is low on both.
- R14: Two slices chained the same way in mode 011 shift a serial stream through all eight bits. The stream enters at the lower slice's `chain_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mreset | input | 1 | Asynchronous master clear, active high |
| mode_sel | input | 3 | Operation chosen for the next clock edge |
| adv_en_n | input | 1 | Local count enable, active low |
| chain_en_n | input | 1 | Cascade count enable, active low; also the serial input for shift-up |
| pre_d | input | WIDTH | Parallel preset data; its MSB is also the serial input for shift-down |
| q | output | WIDTH | Register contents |
| tc_n | output | 1 | Terminal count, active low, in counting modes; copy of the MSB in shift modes |

## Verification
Two functions can meet in one cycle in this block. The first is the lower slice wrapping while the upper slice steps on the same edge. The bench provokes it by counting a two-slice chain through all 256 values and comparing the combined 8-bit value against an arithmetic count after every edge. A missed or doubled carry would show as a jump in that sequence. The second is master reset against a clock edge that carries a load: reset is raised mid-cycle and held across an edge whose mode and data would load a nonzero value, and `q` must read zero both before and after that edge.

// File: rtl/css_pkg.sv
package css_pkg;

   typedef enum logic [2:0] {
      MD_LOAD = 3'd0,
      MD_UP   = 3'd1,
      MD_DOWN = 3'd2,
      MD_SHUP = 3'd3,
      MD_SHDN = 3'd4,
      MD_INV  = 3'd5,
      MD_ZERO = 3'd6,
      MD_HOLD = 3'd7
   } css_mode_e;

   function automatic logic css_is_count(input css_mode_e m);
      return (m == MD_UP) || (m == MD_DOWN);
   endfunction

   function automatic logic css_is_shift(input css_mode_e m);
      return (m == MD_SHUP) || (m == MD_SHDN);
   endfunction

endpackage

// File: rtl/css_step.sv
// Up/down incrementer. STEP_STYLE selects an arithmetic adder (0)
// or an explicit per-bit toggle chain (1).
module css_step #(
   parameter int WIDTH      = 4,
   parameter int STEP_STYLE = 0
) (
   input  logic [WIDTH-1:0] val,
   input  logic             dir_down,
   output logic [WIDTH-1:0] stepped
);

   if (WIDTH < 1) begin : g_chk_width
      $error("css_step: WIDTH must be at least 1");
   end

   if (STEP_STYLE == 0) begin : g_adder
      always_comb begin
         if (dir_down) stepped = val - WIDTH'(1);
         else          stepped = val + WIDTH'(1);
      end
   end else begin : g_toggle
      logic [WIDTH:0] carry;
      assign carry[0] = 1'b1;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign carry[i+1] = carry[i] & (dir_down ? ~val[i] : val[i]);
         assign stepped[i] = val[i] ^ carry[i];
      end
   end

endmodule

// File: rtl/css_shift.sv
// Both shift directions, built per bit with the serial inputs at the ends.
module css_shift #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] val,
   input  logic             ser_lo,
   input  logic             ser_hi,
   output logic [WIDTH-1:0] up_val,
   output logic [WIDTH-1:0] dn_val
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_width
      $error("css_shift: WIDTH must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_up_end
         assign up_val[i] = ser_lo;
      end else begin : g_up_mid
         assign up_val[i] = val[i-1];
      end
      if (i == MSB) begin : g_dn_end
         assign dn_val[i] = ser_hi;
      end else begin : g_dn_mid
         assign dn_val[i] = val[i+1];
      end
   end

endmodule

// File: rtl/css_tc.sv
// Terminal-count / MSB-repeat decode for the cascade output.
module css_tc
   import css_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  css_mode_e        mode,
   input  logic [WIDTH-1:0] val,
   input  logic             chain_en_n,
   output logic             tc_n
);

   localparam int               MSB  = WIDTH - 1;
   localparam logic [WIDTH-1:0] TOPV = {WIDTH{1'b1}};

   always_comb begin
      tc_n = 1'b1;
      unique case (mode)
         MD_UP:   tc_n = ~((val == TOPV) & ~chain_en_n);
         MD_DOWN: tc_n = ~((val == '0)   & ~chain_en_n);
         MD_SHUP,
         MD_SHDN: tc_n = val[MSB];
         default: tc_n = 1'b1;
      endcase
   end

endmodule

// File: rtl/cnt_shift_slice.sv
module cnt_shift_slice
   import css_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter int STEP_STYLE = 0
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic [2:0]       mode_sel,
   input  logic             adv_en_n,
   input  logic             chain_en_n,
   input  logic [WIDTH-1:0] pre_d,
   output logic [WIDTH-1:0] q,
   output logic             tc_n
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_width
      $error("cnt_shift_slice: WIDTH must be at least 2");
   end
   if (STEP_STYLE != 0 && STEP_STYLE != 1) begin : g_chk_style
      $error("cnt_shift_slice: STEP_STYLE must be 0 or 1");
   end

   css_mode_e        mode;
   logic [WIDTH-1:0] state;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] sh_up;
   logic [WIDTH-1:0] sh_dn;
   logic             go;

   assign mode = css_mode_e'(mode_sel);
   assign go   = ~adv_en_n & ~chain_en_n;

   css_step #(.WIDTH(WIDTH), .STEP_STYLE(STEP_STYLE)) u_step (
      .val      (state),
      .dir_down (mode == MD_DOWN),
      .stepped  (stepped)
   );

   css_shift #(.WIDTH(WIDTH)) u_shift (
      .val    (state),
      .ser_lo (chain_en_n),
      .ser_hi (pre_d[MSB]),
      .up_val (sh_up),
      .dn_val (sh_dn)
   );

   css_tc #(.WIDTH(WIDTH)) u_tc (
      .mode       (mode),
      .val        (state),
      .chain_en_n (chain_en_n),
      .tc_n       (tc_n)
   );

   always_comb begin
      nxt = state;
      unique case (mode)
         MD_LOAD: nxt = pre_d;
         MD_UP,
         MD_DOWN: nxt = go ? stepped : state;
         MD_SHUP: nxt = sh_up;
         MD_SHDN: nxt = sh_dn;
         MD_INV:  nxt = ~state;
         MD_ZERO: nxt = '0;
         default: nxt = state;
      endcase
   end

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset) state <= '0;
      else        state <= nxt;
   end

   assign q = state;

   // R1: reset holds the register at zero
   a_r1_reset_clears: assert property (@(posedge clk) mreset |-> q == '0);

   // R2: load
   a_r2_load: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd0) |=> q == $past(pre_d));

   // R3: count up wraps modulo 2^WIDTH
   a_r3_count_up: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd1 && !adv_en_n && !chain_en_n) |=> q == $past(q) + WIDTH'(1));

   // R4: count down wraps modulo 2^WIDTH
   a_r4_count_down: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd2 && !adv_en_n && !chain_en_n) |=> q == $past(q) - WIDTH'(1));

   // R5: either enable high freezes counting
   a_r5_gate_hold: assert property (@(posedge clk) disable iff (mreset)
      ((mode_sel == 3'd1 || mode_sel == 3'd2) && (adv_en_n || chain_en_n)) |=> $stable(q));

   // R7: shift up takes serial bit from the chain enable
   a_r7_shift_up: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd3) |=> q == {$past(q[MSB-1:0]), $past(chain_en_n)});

   // R10: invert
   a_r10_invert: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd5) |=> q == ~$past(q));

   // R11: synchronous clear
   a_r11_clear: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd6) |=> q == '0);

   // R12: hold
   a_r12_hold: assert property (@(posedge clk) disable iff (mreset)
      (mode_sel == 3'd7) |=> $stable(q));

endmodule

// File: tb/cnt_shift_slice_test.sv
`timescale 1ns/1ps
module cnt_shift_slice_test;

   logic       clk = 1'b0;
   logic       mreset;
   logic [2:0] mode_sel;
   logic       adv_en_n;
   logic       lo_chain_n;
   logic [3:0] lo_d, hi_d;
   logic [3:0] lo_q, hi_q;
   logic       lo_tc_n, hi_tc_n;

   int n_checks = 0;
   int n_errs   = 0;

   always #5 clk = ~clk;

   // uut is the lower slice; u_hi is chained above it
   cnt_shift_slice uut (
      .clk(clk), .mreset(mreset), .mode_sel(mode_sel), .adv_en_n(adv_en_n),
      .chain_en_n(lo_chain_n), .pre_d(lo_d), .q(lo_q), .tc_n(lo_tc_n));

   cnt_shift_slice u_hi (
      .clk(clk), .mreset(mreset), .mode_sel(mode_sel), .adv_en_n(adv_en_n),
      .chain_en_n(lo_tc_n), .pre_d(hi_d), .q(hi_q), .tc_n(hi_tc_n));

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_lo(input int v);
      mode_sel = 3'd0;
      lo_d     = 4'(v);
      tick();
   endtask

   initial begin
      #1_000_000;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      mreset = 1'b1; mode_sel = 3'd7; adv_en_n = 1'b1; lo_chain_n = 1'b1;
      lo_d = 4'h0; hi_d = 4'h0;
      repeat (2) @(negedge clk);
      check("R1 reset lo", lo_q, 0);
      check("R1 reset hi", hi_q, 0);
      check("R6 tc idle in hold", lo_tc_n, 1);
      mreset = 1'b0;

      // R2 load every value
      for (int v = 0; v < 16; v++) begin
         load_lo(v);
         check("R2 load", lo_q, v);
         check("R6 tc idle in load", lo_tc_n, 1);
      end

      // R3 / R6 count up
      for (int v = 0; v < 16; v++) begin
         load_lo(v);
         mode_sel = 3'd1; adv_en_n = 1'b0; lo_chain_n = 1'b0;
         #1 check("R6 tc up", lo_tc_n, (v == 15) ? 0 : 1);
         if (v == 15) begin
            lo_chain_n = 1'b1;
            #1 check("R6 tc up chain off", lo_tc_n, 1);
            lo_chain_n = 1'b0;
         end
         tick();
         check("R3 count up", lo_q, (v + 1) % 16);
      end

      // R4 / R6 count down
      for (int v = 0; v < 16; v++) begin
         load_lo(v);
         mode_sel = 3'd2; adv_en_n = 1'b0; lo_chain_n = 1'b0;
         #1 check("R6 tc down", lo_tc_n, (v == 0) ? 0 : 1);
         tick();
         check("R4 count down", lo_q, (v + 15) % 16);
      end

      // R5 enable gating
      for (int md = 1; md <= 2; md++) begin
         for (int p = 1; p <= 3; p++) begin
            for (int v = 0; v < 16; v += 5) begin
               load_lo(v);
               mode_sel = 3'(md); adv_en_n = p[0]; lo_chain_n = p[1];
               tick();
               check("R5 gated hold", lo_q, v);
            end
         end
      end

      // R7 / R9 shift up
      for (int v = 0; v < 16; v++) begin
         for (int s = 0; s < 2; s++) begin
            load_lo(v);
            mode_sel = 3'd3; lo_chain_n = s[0]; adv_en_n = 1'b1;
            tick();
            check("R7 shift up", lo_q, ((v << 1) | s) & 15);
            check("R9 tc follows msb up", lo_tc_n, (((v << 1) | s) >> 3) & 1);
         end
      end

      // R8 / R9 shift down, only pre_d[3] used
      for (int v = 0; v < 16; v++) begin
         for (int b = 0; b < 2; b++) begin
            load_lo(v);
            mode_sel = 3'd4; adv_en_n = 1'b1;
            lo_d = 4'((b << 3) | ((v ^ 5) & 7));
            tick();
            check("R8 shift down", lo_q, (v >> 1) | (b << 3));
            check("R9 tc follows msb down", lo_tc_n, b);
         end
      end

      // R10 invert, R11 clear, R12 hold
      for (int v = 0; v < 16; v++) begin
         load_lo(v);
         mode_sel = 3'd5;
         tick();
         check("R10 invert", lo_q, v ^ 15);
         check("R6 tc idle in invert", lo_tc_n, 1);

         load_lo(v);
         mode_sel = 3'd6;
         tick();
         check("R11 clear", lo_q, 0);

         load_lo(v);
         mode_sel = 3'd7; lo_d = 4'(~v); adv_en_n = 1'b0; lo_chain_n = 1'b0;
         tick();
         lo_chain_n = 1'b1; adv_en_n = 1'b1;
         tick();
         check("R12 hold", lo_q, v);
         check("R6 tc idle in hold", lo_tc_n, 1);
      end

      // R1 async reset mid-cycle, overriding a load edge
      load_lo(10);
      #2 mreset = 1'b1;
      #1 check("R1 async clear before edge", lo_q, 0);
      mode_sel = 3'd0; lo_d = 4'h5;
      @(negedge clk);
      tick();
      check("R1 reset overrides load", lo_q, 0);
      mreset = 1'b0;
      tick();
      check("R1 load after release", lo_q, 5);

      // R13 chained count 0..255 and wrap
      mode_sel = 3'd6; tick();
      mode_sel = 3'd1; adv_en_n = 1'b0; lo_chain_n = 1'b0;
      check("R13 chain start", {hi_q, lo_q}, 0);
      for (int n = 1; n <= 256; n++) begin
         tick();
         check("R13 chain count", {hi_q, lo_q}, n % 256);
      end

      // R14 chained shift of a serial pattern
      mode_sel = 3'd6; adv_en_n = 1'b1; tick();
      begin
         logic [7:0] pat;
         logic [7:0] model;
         pat = 8'hB4; model = 8'h00;
         mode_sel = 3'd3;
         for (int i = 0; i < 8; i++) begin
            lo_chain_n = pat[7-i];
            tick();
            model = {model[6:0], pat[7-i]};
            check("R14 chain shift", {hi_q, lo_q}, model);
         end
         check("R14 pattern landed", {hi_q, lo_q}, 8'hB4);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

endmodule